// File: doc/BRIEF.md
# SCSI Command Block Decoder and Responder

This block sits on the target side of a SCSI link. It collects a command block one byte at a time. Byte 0 is the leading message byte and byte 1 is the operation code. When the final byte arrives, the block decodes the command into a response descriptor. The descriptor gives the transfer direction, the transfer byte count, the starting block address and the block count.

For the two informational commands, the block also builds the reply data from the device-type and sector-count inputs. It sends that reply on a byte stream with a valid/ready handshake. Media access and host DMA belong to the logic around it. That logic reads the descriptor and moves the data.

While a reply is streaming, the command input is held off. This keeps one command from overlapping the next.

Top module: `cdb_responder`

## Requirements
- R1: After reset, `rsp_valid` and `dout_valid` are 0 and `in_ready` is 1.
- R2: A byte is accepted when `in_valid` and `in_ready` are both high. `rsp_valid` is high for exactly the one cycle after the byte marked `in_last` is accepted. The opcode is taken from byte 1. Command bytes that were never received decode as zero. Bytes past index 9 are ignored.
- R3: Opcode 0x12 yields `rsp_dir_in`=1 and `rsp_size`=36, and streams 36 bytes:
  - byte 0 is 5 when `dev_is_cdrom` is high and 0 otherwise;
  - byte 2 is 1 and byte 3 is 2;
  - bytes 8–15 are ASCII "GENERIC ";
  - bytes 16–31 are "VIRTUAL OPTICAL " for a CD-ROM and "VIRTUAL DISK    " otherwise;
  - every other byte is 0.
- R4: Opcode 0x25 yields `rsp_dir_in`=1 and `rsp_size`=8, and streams the 32-bit sector count most significant byte first, followed by 0x00 0x00 0x02 0x00.
- R5: A `sector_count` above 0xFFFFFFFF is reported as 0xFFFFFFFF in the capacity reply.
- R6: Opcode 0x28 yields `rsp_dir_in`=1. `rsp_lba` is bytes 3..6 big-endian. `rsp_blocks` is bytes 8..9 big-endian. `rsp_size` is `rsp_blocks`×512. Nothing is streamed.
- R7: Opcode 0x2A yields `rsp_dir_in`=0, with the address, count and size taken as in R6. Nothing is streamed.
- R8: Opcodes 0x00, 0x1A and any unlisted opcode yield direction 0, size 0, address 0 and count 0, and start no stream.
- R9: A streamed byte and its `dout_last` flag hold steady while `dout_ready` is low. `dout_last` marks the final byte. `dout_valid` falls after the final byte is taken.
- R10: `in_ready` is 0 while a reply streams. Input offered during that time produces no response.
- R11: The first reply byte is presented in the same cycle as the `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte offered |
| in_ready | output | 1 | Command byte can be taken |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Offered byte ends the command block |
| dev_is_cdrom | input | 1 | Device type: 1 CD-ROM, 0 disk |
| sector_count | input | SECT_W | Device size in sectors |
| rsp_valid | output | 1 | Descriptor pulse |
| rsp_dir_in | output | 1 | 1 data to initiator, 0 otherwise |
| rsp_size | output | 25 | Transfer byte count |
| rsp_lba | output | 32 | Starting block address |
| rsp_blocks | output | 16 | Block count |
| dout_valid | output | 1 | Reply byte offered |
| dout_ready | input | 1 | Reply byte taken |
| dout_data | output | 8 | Reply byte |
| dout_last | output | 1 | Final reply byte |

## Verification
The descriptor pulse and the first byte of an inquiry or capacity reply appear in the same cycle. A back-pressured stream can also overlap a new command byte being offered. The bench sends the final command byte and, on the next falling edge, expects `rsp_valid` and `dout_valid` high together. The scoreboard then pops byte 0 as soon as the handshake completes.

With a slow `dout_ready` pattern, the bench offers a one-byte command during the stream. It checks that `in_ready` stays low and that no further descriptor pulse appears.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int BLK_W  = 16;
  localparam int LBA_W  = 32;
  localparam int SIZE_W = BLK_W + 9;

  localparam logic [7:0] OP_TUR  = 8'h00;
  localparam logic [7:0] OP_INQ  = 8'h12;
  localparam logic [7:0] OP_MSNS = 8'h1A;
  localparam logic [7:0] OP_RCAP = 8'h25;
  localparam logic [7:0] OP_RD10 = 8'h28;
  localparam logic [7:0] OP_WR10 = 8'h2A;

  typedef enum logic [1:0] {
    PL_NONE = 2'd0,
    PL_INQ  = 2'd1,
    PL_CAP  = 2'd2
  } payload_e;

  typedef struct packed {
    logic              dir_in;
    logic [SIZE_W-1:0] size;
    logic [LBA_W-1:0]  lba;
    logic [BLK_W-1:0]  blocks;
    payload_e          pl;
  } rsp_t;
endpackage

// File: rtl/cdb_rst_sync.sv
module cdb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cdb_capture.sv
module cdb_capture #(
  parameter int CDB_KEEP = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_ready,
  input  logic [7:0]               in_data,
  input  logic                     in_last,
  output logic [CDB_KEEP-1:0][7:0] cdb_nxt,
  output logic                     cdb_done
);
  localparam int IDX_W = $clog2(CDB_KEEP + 1);

  logic                     accept;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic [CDB_KEEP-1:0][7:0] byte_q;
  logic [CDB_KEEP-1:0]      byte_en;

  assign accept   = in_valid && in_ready;
  assign cdb_done = accept && in_last;

  // First byte of a block clears every stored byte; later bytes land at idx.
  for (genvar g = 0; g < CDB_KEEP; g++) begin : g_byte
    logic first_here, slot_here;
    assign first_here = (idx_q == '0);
    assign slot_here  = (idx_q == IDX_W'(g));
    assign byte_en[g] = accept && (first_here || slot_here);
    always_comb begin
      cdb_nxt[g] = byte_q[g];
      if (byte_en[g]) begin
        if (g == 0)          cdb_nxt[g] = in_data;
        else if (first_here) cdb_nxt[g] = 8'h00;
        else                 cdb_nxt[g] = in_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          byte_q[g] <= 8'h00;
      else if (byte_en[g]) byte_q[g] <= cdb_nxt[g];
    end
  end

  always_comb begin
    idx_d = idx_q;
    if (accept) begin
      if (in_last)                      idx_d = '0;
      else if (idx_q != IDX_W'(CDB_KEEP)) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (accept) idx_q <= idx_d;
  end

  // R2: byte position never runs past the kept window
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(CDB_KEEP));
endmodule

// File: rtl/cdb_decode.sv
module cdb_decode
  import cdb_pkg::*;
#(
  parameter int CDB_KEEP = 10
) (
  input  logic [CDB_KEEP-1:0][7:0] cdb,
  output rsp_t                     rsp
);
  logic [7:0] opcode;
  logic       unused_bytes;

  assign opcode       = cdb[1];
  assign unused_bytes = ^cdb;

  always_comb begin
    rsp        = '0;
    rsp.pl     = PL_NONE;
    case (opcode)
      OP_INQ: begin
        rsp.dir_in = 1'b1;
        rsp.size   = SIZE_W'(36);
        rsp.pl     = PL_INQ;
      end
      OP_RCAP: begin
        rsp.dir_in = 1'b1;
        rsp.size   = SIZE_W'(8);
        rsp.pl     = PL_CAP;
      end
      OP_RD10, OP_WR10: begin
        rsp.dir_in = (opcode == OP_RD10);
        rsp.lba    = {cdb[3], cdb[4], cdb[5], cdb[6]};
        rsp.blocks = {cdb[8], cdb[9]};
        rsp.size   = {cdb[8], cdb[9], 9'b0};
      end
      OP_TUR, OP_MSNS: ;
      default: ;
    endcase
  end
endmodule

// File: rtl/cdb_stream.sv
module cdb_stream
  import cdb_pkg::*;
#(
  parameter int             SECT_W     = 40,
  parameter logic [63:0]    VENDOR_ID  = "GENERIC ",
  parameter logic [127:0]   PROD_DISK  = "VIRTUAL DISK    ",
  parameter logic [127:0]   PROD_CD    = "VIRTUAL OPTICAL "
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  payload_e          kind,
  input  logic              dev_is_cdrom,
  input  logic [SECT_W-1:0] sector_count,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data,
  output logic              dout_last
);
  localparam logic [5:0] INQ_LEN = 6'd36;
  localparam logic [5:0] CAP_LEN = 6'd8;

  logic        act_q, act_d;
  logic [5:0]  idx_q, idx_d;
  logic [5:0]  len_q, len_d;
  payload_e    kind_q, kind_d;
  logic        cd_q, cd_d;
  logic [31:0] cap_q, cap_d;
  logic [31:0] cap_sat;
  logic        upd_en;
  logic [127:0] prod;
  logic [7:0]  byte_d;

  if (SECT_W > 32) begin : g_sat
    assign cap_sat = (|sector_count[SECT_W-1:32]) ? 32'hFFFF_FFFF : sector_count[31:0];
  end else begin : g_nosat
    assign cap_sat = 32'(sector_count);
  end

  assign upd_en = start || (act_q && dout_ready);

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    len_d  = len_q;
    kind_d = kind_q;
    cd_d   = cd_q;
    cap_d  = cap_q;
    if (start) begin
      act_d  = 1'b1;
      idx_d  = 6'd0;
      len_d  = (kind == PL_INQ) ? INQ_LEN : CAP_LEN;
      kind_d = kind;
      cd_d   = dev_is_cdrom;
      cap_d  = cap_sat;
    end else if (act_q && dout_ready) begin
      if (idx_q == len_q - 6'd1) act_d = 1'b0;
      else                       idx_d = idx_q + 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= 6'd0;
      len_q  <= 6'd0;
      kind_q <= PL_NONE;
      cd_q   <= 1'b0;
      cap_q  <= 32'd0;
    end else if (upd_en) begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      kind_q <= kind_d;
      cd_q   <= cd_d;
      cap_q  <= cap_d;
    end
  end

  assign prod = cd_q ? PROD_CD : PROD_DISK;

  always_comb begin
    int pos;
    pos    = int'(idx_q);
    byte_d = 8'h00;
    case (kind_q)
      PL_INQ: begin
        if (pos == 0)                   byte_d = cd_q ? 8'h05 : 8'h00;
        else if (pos == 2)              byte_d = 8'h01;
        else if (pos == 3)              byte_d = 8'h02;
        else if (pos >= 8 && pos < 16)  byte_d = VENDOR_ID[8*(15-pos) +: 8];
        else if (pos >= 16 && pos < 32) byte_d = prod[8*(31-pos) +: 8];
      end
      PL_CAP: begin
        if (pos < 4)       byte_d = cap_q[8*(3-pos) +: 8];
        else if (pos == 6) byte_d = 8'h02;
      end
      default: byte_d = 8'h00;
    endcase
  end

  assign dout_valid = act_q;
  assign dout_data  = byte_d;
  assign dout_last  = act_q && (idx_q == len_q - 6'd1);

  // R9: stalled byte is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_data) && $stable(dout_last));
  // R9: stream ends after the final byte is taken
  a_r9_end: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && dout_ready && dout_last |=> !dout_valid);
  // R9: position stays inside the reply
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> idx_q < len_q);
endmodule

// File: rtl/cdb_responder.sv
module cdb_responder
  import cdb_pkg::*;
#(
  parameter int SECT_W   = 40,
  parameter int CDB_KEEP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              dev_is_cdrom,
  input  logic [SECT_W-1:0] sector_count,
  output logic              rsp_valid,
  output logic              rsp_dir_in,
  output logic [24:0]       rsp_size,
  output logic [31:0]       rsp_lba,
  output logic [15:0]       rsp_blocks,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data,
  output logic              dout_last
);
  logic                     rst_n_i;
  logic [CDB_KEEP-1:0][7:0] cdb_nxt;
  logic                     cdb_done;
  rsp_t                     dec, rsp_q, rsp_d;
  logic                     rsp_valid_q;
  logic                     stream_start;
  logic                     unused_pl;

  cdb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  cdb_capture #(.CDB_KEEP(CDB_KEEP)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .cdb_nxt  (cdb_nxt),
    .cdb_done (cdb_done)
  );

  cdb_decode #(.CDB_KEEP(CDB_KEEP)) u_dec (
    .cdb (cdb_nxt),
    .rsp (dec)
  );

  assign stream_start = cdb_done && (dec.pl != PL_NONE);

  cdb_stream #(.SECT_W(SECT_W)) u_str (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .start        (stream_start),
    .kind         (dec.pl),
    .dev_is_cdrom (dev_is_cdrom),
    .sector_count (sector_count),
    .dout_valid   (dout_valid),
    .dout_ready   (dout_ready),
    .dout_data    (dout_data),
    .dout_last    (dout_last)
  );

  assign in_ready = !dout_valid;

  always_comb begin
    rsp_d = rsp_q;
    if (cdb_done) rsp_d = dec;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
    end else begin
      rsp_valid_q <= cdb_done;
      if (cdb_done) rsp_q <= rsp_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_dir_in = rsp_q.dir_in;
  assign rsp_size   = rsp_q.size;
  assign rsp_lba    = rsp_q.lba;
  assign rsp_blocks = rsp_q.blocks;
  assign unused_pl  = ^rsp_q.pl;

  // R2: last accepted byte produces a descriptor next cycle
  a_r2_resp: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_valid && in_ready && in_last |=> rsp_valid);
  // R10: no descriptor follows a cycle where input was blocked
  a_r10_no_resp: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_ready |=> !rsp_valid);
  // R11: inquiry descriptor arrives together with its first byte
  a_r11_together: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid && rsp_dir_in && (rsp_size == 25'd36) |-> dout_valid);
endmodule

// File: tb/cdb_responder_bench.sv
module cdb_responder_bench;
  localparam int CLK_P  = 10;
  localparam int SECT_W = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready, in_last;
  logic [7:0]        in_data;
  logic              dev_is_cdrom;
  logic [SECT_W-1:0] sector_count;
  logic              rsp_valid, rsp_dir_in;
  logic [24:0]       rsp_size;
  logic [31:0]       rsp_lba;
  logic [15:0]       rsp_blocks;
  logic              dout_valid, dout_ready, dout_last;
  logic [7:0]        dout_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit slow_ready = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] cdb [0:11];

  always #(CLK_P/2) clk = ~clk;

  cdb_responder #(.SECT_W(SECT_W)) u_cdb_responder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .dev_is_cdrom(dev_is_cdrom),
    .sector_count(sector_count), .rsp_valid(rsp_valid), .rsp_dir_in(rsp_dir_in),
    .rsp_size(rsp_size), .rsp_lba(rsp_lba), .rsp_blocks(rsp_blocks),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .dout_last(dout_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern changes 2 time units after each rising edge
  initial begin
    dout_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      dout_ready = slow_ready ? (cyc % 3 == 0) : 1'b1;
    end
  end

  // scoreboard monitor
  initial begin
    bit         stalled = 1'b0;
    logic [8:0] held = '0;
    forever begin
      @(negedge clk);
      if (stalled && dout_valid)
        chk({dout_last, dout_data} == held, "R9 hold", {dout_last, dout_data}, held);
      if (dout_valid && dout_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected byte", {dout_last, dout_data}, 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({dout_last, dout_data} == e, t, {dout_last, dout_data}, e);
        end
      end
      stalled = dout_valid && !dout_ready;
      held    = {dout_last, dout_data};
    end
  end

  task automatic push_inq(input bit cd);
    string vend, prod;
    vend = "GENERIC ";
    prod = cd ? "VIRTUAL OPTICAL " : "VIRTUAL DISK    ";
    for (int i = 0; i < 36; i++) begin
      logic [7:0] b;
      b = 8'h00;
      if (i == 0) b = cd ? 8'h05 : 8'h00;
      else if (i == 2) b = 8'h01;
      else if (i == 3) b = 8'h02;
      else if (i >= 8 && i < 16) b = vend[i-8];
      else if (i >= 16 && i < 32) b = prod[i-16];
      exp_q.push_back({(i == 35), b});
      tag_q.push_back("R3 inquiry byte");
    end
  endtask

  task automatic push_cap(input logic [SECT_W-1:0] n, input string t);
    logic [31:0] s;
    logic [7:0]  tail [0:3];
    s = (n > 40'hFF_FFFF_FFFF >> 8) ? 32'hFFFF_FFFF : n[31:0];
    tail[0] = 8'h00; tail[1] = 8'h00; tail[2] = 8'h02; tail[3] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back({1'b0, s[8*(3-i) +: 8]});
      tag_q.push_back(t);
    end
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back({(i == 3), tail[i]});
      tag_q.push_back(t);
    end
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = cdb[i];
      in_last  = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic chk_rsp(input string t, input bit dir, input logic [24:0] size,
                         input logic [31:0] lba, input logic [15:0] blk, input bit strm);
    chk(rsp_valid == 1'b1, {t, " pulse"}, rsp_valid, 1);
    chk(rsp_dir_in == dir, {t, " dir"}, rsp_dir_in, dir);
    chk(rsp_size == size, {t, " size"}, rsp_size, size);
    chk(rsp_lba == lba, {t, " lba"}, rsp_lba, lba);
    chk(rsp_blocks == blk, {t, " blocks"}, rsp_blocks, blk);
    chk(dout_valid == strm, {t, " R11 stream start"}, dout_valid, strm);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || dout_valid);
  endtask

  task automatic clear_cdb();
    for (int i = 0; i < 12; i++) cdb[i] = 8'h00;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    dev_is_cdrom = 1'b0;
    sector_count = 40'd0;
    clear_cdb();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(dout_valid == 1'b0, "R1 dout_valid", dout_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 inquiry, disk, free-running ready
    clear_cdb(); cdb[0] = 8'h80; cdb[1] = 8'h12; cdb[5] = 8'd36;
    push_inq(1'b0);
    send(6);
    chk_rsp("R3 inquiry disk", 1'b1, 25'd36, 32'd0, 16'd0, 1'b1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 single pulse", rsp_valid, 0);
    wait_idle();

    // R3 inquiry, CD-ROM, slow ready; R10 input blocked during stream
    slow_ready = 1'b1;
    dev_is_cdrom = 1'b1;
    push_inq(1'b1);
    send(6);
    chk_rsp("R3 inquiry cd", 1'b1, 25'd36, 32'd0, 16'd0, 1'b1);
    in_valid = 1'b1; in_data = 8'h00; in_last = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R10 in_ready low", in_ready, 0);
      chk(rsp_valid == 1'b0, "R10 no response", rsp_valid, 0);
    end
    in_valid = 1'b0; in_last = 1'b0;
    wait_idle();
    dev_is_cdrom = 1'b0;

    // R4 read capacity
    sector_count = 40'h00_1234_5678;
    clear_cdb(); cdb[1] = 8'h25;
    push_cap(sector_count, "R4 capacity byte");
    send(10);
    chk_rsp("R4 capacity", 1'b1, 25'd8, 32'd0, 16'd0, 1'b1);
    wait_idle();

    // R5 saturation
    sector_count = 40'h01_0000_0005;
    push_cap(sector_count, "R5 saturated byte");
    send(10);
    chk_rsp("R5 capacity", 1'b1, 25'd8, 32'd0, 16'd0, 1'b1);
    wait_idle();
    slow_ready = 1'b0;

    // R6 read(10)
    clear_cdb(); cdb[1] = 8'h28; cdb[3] = 8'h01; cdb[4] = 8'h02; cdb[5] = 8'h03;
    cdb[6] = 8'h04; cdb[9] = 8'h03;
    send(10);
    chk_rsp("R6 read", 1'b1, 25'd1536, 32'h0102_0304, 16'd3, 1'b0);

    // R7 write(10), largest count
    clear_cdb(); cdb[1] = 8'h2A; cdb[3] = 8'hDE; cdb[4] = 8'hAD; cdb[5] = 8'hBE;
    cdb[6] = 8'hEF; cdb[8] = 8'hFF; cdb[9] = 8'hFF;
    send(10);
    chk_rsp("R7 write", 1'b0, 25'(32'hFFFF * 512), 32'hDEAD_BEEF, 16'hFFFF, 1'b0);

    // R8 zero-transfer commands
    clear_cdb(); cdb[1] = 8'h00;
    send(6);
    chk_rsp("R8 test ready", 1'b0, 25'd0, 32'd0, 16'd0, 1'b0);
    clear_cdb(); cdb[1] = 8'h1A; cdb[3] = 8'h3F;
    send(6);
    chk_rsp("R8 mode sense", 1'b0, 25'd0, 32'd0, 16'd0, 1'b0);
    clear_cdb(); cdb[1] = 8'h5A; cdb[3] = 8'h11; cdb[9] = 8'h22;
    send(10);
    chk_rsp("R8 unknown", 1'b0, 25'd0, 32'd0, 16'd0, 1'b0);

    // R2 short block: missing bytes decode as zero
    clear_cdb(); cdb[1] = 8'h28; cdb[2] = 8'hAA; cdb[3] = 8'hBB;
    send(4);
    chk_rsp("R2 short block", 1'b1, 25'd0, 32'hBB00_0000, 16'd0, 1'b0);

    // R2 long block: bytes past index 9 ignored
    clear_cdb(); cdb[1] = 8'h28; cdb[6] = 8'h07; cdb[9] = 8'h02;
    cdb[10] = 8'hFF; cdb[11] = 8'hFF;
    send(12);
    chk_rsp("R2 long block", 1'b1, 25'd1024, 32'h0000_0007, 16'd2, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all bytes seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule